// File: doc/BRIEF.md
# Bit-Serial Multicycle Adder

This block adds two operands one bit position per clock. It uses one full-adder cell and a carry flip-flop whose output returns as the carry-in of the next bit. It does not use a full-width ripple chain. When the block is idle, a start request copies both operands into shift registers, clears the result register and clears the carry. The least significant bit goes through the cell first, and each sum bit shifts into the result register.

A size select, sampled with the start request, picks the operand width. A byte addition processes the low eight bits and takes eight cycles. A word addition processes all thirty-two bits and takes thirty-two cycles. When the last bit is written, a single-cycle done pulse marks the result as valid. The sum and the carry-out then stay unchanged until the next accepted start.

Top module: `bitser_add`

## Requirements
- R1: After reset, sum_o is 0, cout_o is 0, busy_o is 0 and done_o is 0.
- R2: A start_i sampled high while busy_o is low loads both operands, clears the sum register and clears the carry flip-flop at that edge. busy_o is high from the next cycle.
- R3: With wide_i = 1 (word) at start, sum_o equals (a+b) mod 2^32 and cout_o equals bit 32 of a+b. done_o rises 32 clock edges after the start edge.
- R4: With wide_i = 0 (byte) at start, only bits 7:0 are added. sum_o[7:0] holds the low eight bits of a[7:0]+b[7:0], sum_o[31:8] is 0, and cout_o is the carry from bit 7. done_o rises 8 edges after the start edge. Operand bits 31:8 have no effect.
- R5: done_o is high for exactly one cycle per addition. busy_o is low in that cycle and stays high from the cycle after start until then.
- R6: start_i sampled while busy_o is high is ignored. The result and timing of the running addition are unchanged.
- R7: While idle, sum_o and cout_o hold their values until the next accepted start.
- R8: wide_i is sampled only with an accepted start. A change during an addition does not alter its length or result.
- R9: A start_i given in the cycle where done_o is high is accepted, because the block is idle then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, honoured when idle |
| wide_i | input | 1 | 1 = word (32 bits), 0 = byte (8 bits) |
| opa_i | input | 32 | First operand |
| opb_i | input | 32 | Second operand |
| sum_o | output | 32 | Sum, zero-extended in byte mode |
| cout_o | output | 1 | Carry out of the top processed bit |
| busy_o | output | 1 | Addition in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The hardest situation to reach is a start request in the single done cycle. It needs a stimulus timed from the observed done pulse rather than from a fixed delay. The bench watches done_o at each falling edge and raises start_i in that same cycle. Other stimulus holds start_i high and toggles wide_i while an addition runs, to show that neither changes the running operation. The byte operands carry nonzero upper bits that must not appear in the result.

// File: rtl/bsa_pkg.sv
package bsa_pkg;
  typedef enum logic {
    SZ_BYTE = 1'b0,
    SZ_WORD = 1'b1
  } bsa_size_e;
endpackage

// File: rtl/bsa_oprnd_sr.sv
module bsa_oprnd_sr #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         shift,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  output logic         a_bit,
  output logic         b_bit
);
  logic [W-1:0] a_q, a_d, b_q, b_d;

  always_comb begin
    a_d = a_q;
    b_d = b_q;
    if (load) begin
      a_d = a_in;
      b_d = b_in;
    end else if (shift) begin
      a_d = a_q >> 1;
      b_d = b_q >> 1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= '0;
      b_q <= '0;
    end else if (load || shift) begin
      a_q <= a_d;
      b_q <= b_d;
    end
  end

  assign a_bit = a_q[0];
  assign b_bit = b_q[0];
endmodule

// File: rtl/bsa_fa_cell.sv
module bsa_fa_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  input  logic a,
  input  logic b,
  output logic s,
  output logic carry_q
);
  logic c_next, carry_d;

  always_comb begin
    s       = a ^ b ^ carry_q;
    c_next  = (a & b) | (a & carry_q) | (b & carry_q);
    carry_d = clr ? 1'b0 : c_next;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         carry_q <= 1'b0;
    else if (clr || en) carry_q <= carry_d;
  end

  // R2: a cleared carry starts every addition
  a_r2_carry_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (carry_q == 1'b0));
  // R7: carry holds when neither cleared nor stepped
  a_r7_carry_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !en) |=> $stable(carry_q));
endmodule

// File: rtl/bsa_sum_sr.sv
module bsa_sum_sr #(
  parameter int W      = 32,
  parameter int NARROW = 8,
  parameter int CW     = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          shift,
  input  logic [CW-1:0] ins_pos,
  input  logic          bit_in,
  output logic [W-1:0]  sum_q
);
  logic [W-1:0] sum_d;

  always_comb begin
    sum_d = sum_q;
    if (clr) begin
      sum_d = '0;
    end else if (shift) begin
      sum_d = sum_q >> 1;
      sum_d[ins_pos] = bit_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            sum_q <= '0;
    else if (clr || shift) sum_q <= sum_d;
  end

  // R7: result holds while idle
  a_r7_sum_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !shift) |=> $stable(sum_q));
  // R4: byte results never reach the upper bits
  a_r4_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_pos == CW'(NARROW-1)) |-> (sum_q[W-1:NARROW] == '0));
endmodule

// File: rtl/bsa_ctrl.sv
module bsa_ctrl
  import bsa_pkg::*;
#(
  parameter int W      = 32,
  parameter int NARROW = 8,
  parameter int CW     = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          wide_i,
  output logic          load_o,
  output logic          step_o,
  output logic [CW-1:0] ins_pos_o,
  output logic          busy_o,
  output logic          done_o
);
  localparam logic [CW-1:0] LastWide   = CW'(W-1);
  localparam logic [CW-1:0] LastNarrow = CW'(NARROW-1);

  logic          busy_q, busy_d, done_q, done_d, last;
  logic [CW-1:0] cnt_q, cnt_d;
  bsa_size_e     size_q, size_d;

  always_comb begin
    load_o = start_i & ~busy_q;
    step_o = busy_q;
    last   = busy_q && (cnt_q == '0);
    busy_d = busy_q;
    cnt_d  = cnt_q;
    size_d = size_q;
    done_d = last;
    if (load_o) begin
      busy_d = 1'b1;
      size_d = wide_i ? SZ_WORD : SZ_BYTE;
      cnt_d  = wide_i ? LastWide : LastNarrow;
    end else if (last) begin
      busy_d = 1'b0;
    end else if (busy_q) begin
      cnt_d = cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
      size_q <= SZ_BYTE;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      if (load_o || busy_q) cnt_q  <= cnt_d;
      if (load_o)           size_q <= size_d;
    end
  end

  assign ins_pos_o = (size_q == SZ_WORD) ? LastWide : LastNarrow;
  assign busy_o    = busy_q;
  assign done_o    = done_q;

  // R5: done is a single-cycle pulse
  a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  // R5: busy and done never overlap
  a_r5_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy_q);
  // R5: busy only ends with a done pulse
  a_r5_busy_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> done_q);
  // R6: a start during an addition does not disturb the count
  a_r6_count_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cnt_q != '0) |=> (busy_q && cnt_q == $past(cnt_q) - CW'(1)));
  // R8: operand size is frozen while busy
  a_r8_size_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> $stable(size_q));
endmodule

// File: rtl/bitser_add.sv
module bitser_add #(
  parameter int W      = 32,
  parameter int NARROW = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic         wide_i,
  input  logic [W-1:0] opa_i,
  input  logic [W-1:0] opb_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o,
  output logic         busy_o,
  output logic         done_o
);
  localparam int CW = $clog2(W);

  logic          load, step, a_bit, b_bit, s_bit;
  logic [CW-1:0] ins_pos;

  bsa_ctrl #(.W(W), .NARROW(NARROW), .CW(CW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .wide_i(wide_i),
    .load_o(load), .step_o(step), .ins_pos_o(ins_pos),
    .busy_o(busy_o), .done_o(done_o)
  );

  bsa_oprnd_sr #(.W(W)) u_ops (
    .clk(clk), .rst_n(rst_n), .load(load), .shift(step),
    .a_in(opa_i), .b_in(opb_i), .a_bit(a_bit), .b_bit(b_bit)
  );

  bsa_fa_cell u_fa (
    .clk(clk), .rst_n(rst_n), .clr(load), .en(step),
    .a(a_bit), .b(b_bit), .s(s_bit), .carry_q(cout_o)
  );

  bsa_sum_sr #(.W(W), .NARROW(NARROW), .CW(CW)) u_sum (
    .clk(clk), .rst_n(rst_n), .clr(load), .shift(step),
    .ins_pos(ins_pos), .bit_in(s_bit), .sum_q(sum_o)
  );

  // R2: an idle start clears the result and raises busy
  a_r2_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> (busy_o && sum_o == '0 && !cout_o));
endmodule

// File: tb/bitser_add_bench.sv
module bitser_add_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        wide_i = 1'b0;
  logic [31:0] opa_i = '0, opb_i = '0;
  logic [31:0] sum_o;
  logic        cout_o, busy_o, done_o;

  int tests = 0, fails = 0, cycles = 0;
  string cur_req = "R1";

  bitser_add u_bitser_add (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .wide_i(wide_i),
    .opa_i(opa_i), .opb_i(opb_i), .sum_o(sum_o), .cout_o(cout_o),
    .busy_o(busy_o), .done_o(done_o)
  );

  always #2 clk = ~clk;

  // behavioural reference model
  logic        m_busy = 0, m_done = 0, m_cout = 0, m_rc = 0;
  logic [31:0] m_sum = 0, m_res = 0;
  int          m_left = 0;

  always @(posedge clk) begin
    logic old_busy;
    logic [32:0] full;
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_sum = 0; m_cout = 0; m_left = 0;
    end else begin
      old_busy = m_busy;
      m_done = 0;
      if (m_busy) begin
        m_left--;
        if (m_left == 0) begin
          m_busy = 0; m_done = 1; m_sum = m_res; m_cout = m_rc;
        end
      end
      if (start_i && !old_busy) begin
        if (wide_i) begin
          full  = {1'b0, opa_i} + {1'b0, opb_i};
          m_res = full[31:0]; m_rc = full[32]; m_left = 32;
        end else begin
          full  = {25'b0, opa_i[7:0]} + {25'b0, opb_i[7:0]};
          m_res = {24'b0, full[7:0]}; m_rc = full[8]; m_left = 8;
        end
        m_busy = 1; m_sum = 0; m_cout = 0;
      end
    end
  end

  task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", cur_req, what, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      cycles++;
      chk(busy_o == m_busy, "busy", 64'(busy_o), 64'(m_busy));
      chk(done_o == m_done, "done", 64'(done_o), 64'(m_done));
      if (!m_busy) begin
        chk(sum_o == m_sum, "sum", 64'(sum_o), 64'(m_sum));
        chk(cout_o == m_cout, "cout", 64'(cout_o), 64'(m_cout));
      end
    end
  end

  // launch an addition and wait for done; checks latency and result
  task automatic run_op(input logic [31:0] a, input logic [31:0] b, input bit w,
                        input string req, input bit noisy);
    int n, k;
    logic [32:0] full;
    logic [31:0] er;
    logic ec;
    cur_req = req;
    if (w) begin full = {1'b0,a} + {1'b0,b}; er = full[31:0]; ec = full[32]; n = 32; end
    else begin full = {25'b0,a[7:0]} + {25'b0,b[7:0]}; er = {24'b0,full[7:0]}; ec = full[8]; n = 8; end
    opa_i = a; opb_i = b; wide_i = w; start_i = 1'b1;
    k = 0;
    @(negedge clk);
    if (!noisy) start_i = 1'b0;
    k = 1;
    while (!done_o && k < 40) begin
      if (noisy) begin
        // R6 R8: disturb inputs while busy
        start_i = 1'b1; wide_i = ~wide_i; opa_i = ~opa_i; opb_i = opb_i + 32'h1111;
      end
      @(negedge clk);
      k++;
    end
    start_i = 1'b0;
    chk(k == n + 1, "latency", 64'(k), 64'(n + 1));
    chk(sum_o == er, "sum at done", 64'(sum_o), 64'(er));
    chk(cout_o == ec, "cout at done", 64'(cout_o), 64'(ec));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    cur_req = "R1";
    chk(sum_o == 0, "reset sum", 64'(sum_o), 0);
    chk(cout_o == 0, "reset cout", 64'(cout_o), 0);
    chk(busy_o == 0, "reset busy", 64'(busy_o), 0);
    chk(done_o == 0, "reset done", 64'(done_o), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 word additions
    run_op(32'h0000_0000, 32'h0000_0000, 1, "R3", 0);
    run_op(32'hFFFF_FFFF, 32'h0000_0001, 1, "R3", 0);
    run_op(32'h7FFF_FFFF, 32'h0000_0001, 1, "R3", 0);
    run_op(32'h1234_5678, 32'h9ABC_DEF0, 1, "R3", 0);
    run_op(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1, "R3", 0);

    // R4 byte additions, upper operand bits must be ignored
    run_op(32'hABCD_EFFF, 32'h5555_5501, 0, "R4", 0);
    run_op(32'hFFFF_FF7F, 32'h0000_0001, 0, "R4", 0);
    run_op(32'h0000_0012, 32'hFFFF_FF34, 0, "R4", 0);

    // R7 hold while idle
    cur_req = "R7";
    opa_i = 32'hDEAD_BEEF; opb_i = 32'hCAFE_F00D; wide_i = 1;
    repeat (10) @(negedge clk);
    chk(sum_o == 32'h46, "idle hold sum", 64'(sum_o), 64'h46);

    // R2 start clears sum and raises busy
    cur_req = "R2";
    opa_i = 32'h1; opb_i = 32'h1; wide_i = 1; start_i = 1;
    @(negedge clk);
    start_i = 0;
    chk(busy_o == 1, "busy after start", 64'(busy_o), 1);
    chk(sum_o == 0, "sum cleared", 64'(sum_o), 0);
    chk(cout_o == 0, "carry cleared", 64'(cout_o), 0);
    while (!done_o) @(negedge clk);
    @(negedge clk);

    // R6 R8 noisy start and size toggling during addition
    run_op(32'h8000_00F0, 32'h8000_0020, 1, "R6", 1);
    @(negedge clk);
    run_op(32'h0000_00C8, 32'h0000_0064, 0, "R8", 1);

    // R5 done pulse lasts one cycle
    cur_req = "R5";
    @(negedge clk);
    chk(done_o == 0, "done single cycle", 64'(done_o), 0);

    // R9 back-to-back start in the done cycle
    run_op(32'h0F0F_0F0F, 32'hF0F0_F0F1, 1, "R9", 0);
    run_op(32'h0000_0080, 32'h0000_0080, 0, "R9", 0);
    run_op(32'h0000_0003, 32'h0000_0004, 1, "R9", 0);
    repeat (3) @(negedge clk);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule